// File: doc/BRIEF.md
# Core power-on reset sequencer

This block brings one secondary processor core from the unpowered state to a running state. It runs a fixed, timed series of steps. First it raises a supply rail request with a voltage code. Then it applies an ordered set of clamp, power-on-reset and cache-sleep transitions to a nine-bit control word. The last step sets the core-powered-up bit. Each step holds for its own minimum time before the next one starts.

A single-cycle start pulse launches the sequence. The minimum delays are given in time units. Each one is turned into a cycle count from the `CLK_HZ` parameter and rounded up, so no wait is ever shorter than its minimum. The block reports busy while the sequence runs and done once it has finished. After done is set, only a reset can run the sequence again.

Top module: `core_pwrup_seq`

## Requirements
- R1: While reset is held, and after reset until a start pulse arrives, the outputs are: `ctrl_o` = 0, `rail_en_o` = 0, `rail_code_o` = 0, `busy_o` = 0 and `done_o` = 0.
- R2: In the cycle after start is sampled, `rail_en_o` goes high with `rail_code_o` = 8'hA4 and `busy_o` goes high. The control word stays 0 for ceil(512 us · CLK_HZ) cycles. The rail request stays on from then until reset.
- R3: The first non-zero control word is 9'h109 (PLL clamp bit 8, L2 sleep bit 3, output clamp bit 0) and lasts exactly one cycle. It is followed by 9'h101, with L2 sleep cleared.
- R4: 9'h101 lasts ceil(300 ns · CLK_HZ) cycles. Then the power-on reset bit 5 is set, giving 9'h121.
- R5: 9'h121 lasts ceil(2 us · CLK_HZ) cycles. Then output clamp is cleared, giving 9'h120, which lasts another ceil(2 us · CLK_HZ) cycles. Output clamp only falls while power-on reset is high.
- R6: Power-on reset is then released, giving 9'h100, which lasts ceil(100 us · CLK_HZ) cycles. Then core-powered-up bit 7 is set, giving 9'h180, which holds until reset.
- R7: `done_o` rises one cycle after 9'h180 first appears and stays high until reset. `busy_o` falls in the same cycle. Busy and done are never high together.
- R8: A start pulse while busy, or after done, has no effect on any output.
- R9: Core reset (bit 4) and bits 6, 2 and 1 stay 0 at all times. A fractional delay rounds up to a whole cycle, so 300 ns at 3 MHz gives 1 cycle.
- R10: A reset in the middle of the sequence returns all outputs to the R1 state at once. A following start runs the whole sequence again from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, one cycle |
| ctrl_o | output | 9 | Core power control word |
| rail_en_o | output | 1 | Supply rail enable request |
| rail_code_o | output | 8 | Requested rail voltage code |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete, held until reset |

## Verification
The bench builds two instances, one with `CLK_HZ` = 10 MHz and one with `CLK_HZ` = 3 MHz. At these frequencies a whole sequence takes a few thousand cycles, so every cycle of every step can be compared against an arithmetic timeline. At 3 MHz the 300 ns step needs 0.9 of a cycle, which tests the rounding-up rule. Because the two instances share their start and reset inputs, the pulses sent during one run land while one instance is still busy and the other is already done. A reset in mid-sequence followed by a second full run checks that the block can restart.

// File: rtl/core_pwrup_pkg.sv
package core_pwrup_pkg;
  localparam int CW_W          = 9;
  localparam int PLL_CLAMP_BIT = 8;
  localparam int PWRD_UP_BIT   = 7;
  localparam int POR_BIT       = 5;
  localparam int CORE_RST_BIT  = 4;
  localparam int L2_SLEEP_BIT  = 3;
  localparam int OUT_CLAMP_BIT = 0;
  localparam logic [7:0] RAIL_CODE = 8'hA4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RAIL, ST_L2_SET, ST_L2_CLR,
    ST_POR_ON, ST_UNCLAMP, ST_POR_OFF, ST_UP
  } step_e;

  // ceil(t_ns * clk_hz / 1e9), never below one cycle
  function automatic longint ns_to_cycles(longint t_ns, longint clk_hz);
    longint c;
    c = (t_ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 64'd1 : c;
  endfunction

  function automatic logic [CW_W-1:0] step_word(step_e s);
    logic [CW_W-1:0] w;
    w = '0;
    unique case (s)
      ST_L2_SET:  begin w[PLL_CLAMP_BIT] = 1'b1; w[L2_SLEEP_BIT] = 1'b1; w[OUT_CLAMP_BIT] = 1'b1; end
      ST_L2_CLR:  begin w[PLL_CLAMP_BIT] = 1'b1; w[OUT_CLAMP_BIT] = 1'b1; end
      ST_POR_ON:  begin w[PLL_CLAMP_BIT] = 1'b1; w[OUT_CLAMP_BIT] = 1'b1; w[POR_BIT] = 1'b1; end
      ST_UNCLAMP: begin w[PLL_CLAMP_BIT] = 1'b1; w[POR_BIT] = 1'b1; end
      ST_POR_OFF: begin w[PLL_CLAMP_BIT] = 1'b1; end
      ST_UP:      begin w[PLL_CLAMP_BIT] = 1'b1; w[PWRD_UP_BIT] = 1'b1; end
      default:    w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/pwrup_wait_rom.sv
module pwrup_wait_rom
  import core_pwrup_pkg::*;
#(
  parameter longint CLK_HZ = 200_000_000,
  parameter int     CNT_W  = 17
) (
  input  step_e            step_i,
  output logic [CNT_W-1:0] load_val_o
);
  localparam longint W_RAIL = ns_to_cycles(512_000, CLK_HZ);
  localparam longint W_L2   = ns_to_cycles(300, CLK_HZ);
  localparam longint W_POR  = ns_to_cycles(2_000, CLK_HZ);
  localparam longint W_UNCL = ns_to_cycles(2_000, CLK_HZ);
  localparam longint W_REL  = ns_to_cycles(100_000, CLK_HZ);

  // load value is hold length minus one
  always_comb begin
    unique case (step_i)
      ST_RAIL:    load_val_o = CNT_W'(W_RAIL - 1);
      ST_L2_CLR:  load_val_o = CNT_W'(W_L2 - 1);
      ST_POR_ON:  load_val_o = CNT_W'(W_POR - 1);
      ST_UNCLAMP: load_val_o = CNT_W'(W_UNCL - 1);
      ST_POR_OFF: load_val_o = CNT_W'(W_REL - 1);
      default:    load_val_o = '0;
    endcase
  end
endmodule

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R9
  zero_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
  import core_pwrup_pkg::*;
#(
  parameter longint CLK_HZ = 200_000_000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic [CW_W-1:0] ctrl_o,
  output logic            rail_en_o,
  output logic [7:0]      rail_code_o,
  output logic            busy_o,
  output logic            done_o
);
  localparam longint W_MAX = ns_to_cycles(512_000, CLK_HZ);
  localparam int     CNT_W = $clog2(W_MAX + 1);

  step_e            state_q, state_d;
  logic             tmr_zero, tmr_load, done_q;
  logic [CNT_W-1:0] tmr_val;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i)  state_d = ST_RAIL;
      ST_RAIL:    if (tmr_zero) state_d = ST_L2_SET;
      ST_L2_SET:  if (tmr_zero) state_d = ST_L2_CLR;
      ST_L2_CLR:  if (tmr_zero) state_d = ST_POR_ON;
      ST_POR_ON:  if (tmr_zero) state_d = ST_UNCLAMP;
      ST_UNCLAMP: if (tmr_zero) state_d = ST_POR_OFF;
      ST_POR_OFF: if (tmr_zero) state_d = ST_UP;
      ST_UP:                    state_d = ST_UP;
      default:                  state_d = ST_IDLE;
    endcase
  end

  assign tmr_load = (state_d != state_q);

  pwrup_wait_rom #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_rom (
    .step_i     (state_d),
    .load_val_o (tmr_val)
  );

  pwrup_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_q | (state_q == ST_UP);
    end
  end

  assign ctrl_o      = step_word(state_q);
  assign rail_en_o   = (state_q != ST_IDLE);
  assign rail_code_o = rail_en_o ? RAIL_CODE : 8'h00;
  assign busy_o      = rail_en_o & ~done_q;
  assign done_o      = done_q;

  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  // R7
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R2
  rail_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o != '0) |-> rail_en_o);
  // R5
  clamp_under_por_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[OUT_CLAMP_BIT]) |-> ctrl_o[POR_BIT]);
  // R6
  pwrup_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[PWRD_UP_BIT]) |-> (!ctrl_o[POR_BIT] && !ctrl_o[OUT_CLAMP_BIT]));
  // R8
  start_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> ($stable(ctrl_o) && done_o));
  // R9
  core_rst_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[CORE_RST_BIT]);
endmodule

// File: tb/core_pwrup_seq_test.sv
module core_pwrup_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  int   checks = 0;
  int   fails = 0;
  logic done_flag = 1'b0;

  logic [8:0] ctrl_a, ctrl_b;
  logic       rail_a, rail_b, busy_a, busy_b, done_a, done_b;
  logic [7:0] code_a, code_b;

  always #2.5 clk = ~clk;

  core_pwrup_seq #(.CLK_HZ(10_000_000)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ctrl_o(ctrl_a),
    .rail_en_o(rail_a), .rail_code_o(code_a), .busy_o(busy_a), .done_o(done_a));

  core_pwrup_seq #(.CLK_HZ(3_000_000)) uut_slow (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ctrl_o(ctrl_b),
    .rail_en_o(rail_b), .rail_code_o(code_b), .busy_o(busy_b), .done_o(done_b));

  function automatic int cyc(longint t_ns, longint hz);
    longint c;
    c = (t_ns * hz + 999_999_999) / 1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  // expected {ctrl, rail, code, busy, done} k cycles after the start edge
  function automatic logic [19:0] expect_at(int k, longint hz);
    int b1, b2, b3, b4, b5, b6;
    logic [8:0] c;
    b1 = cyc(512_000, hz);
    b2 = b1 + 1;
    b3 = b2 + cyc(300, hz);
    b4 = b3 + cyc(2_000, hz);
    b5 = b4 + cyc(2_000, hz);
    b6 = b5 + cyc(100_000, hz);
    if (k < b1)      c = 9'h000;
    else if (k < b2) c = 9'h109;
    else if (k < b3) c = 9'h101;
    else if (k < b4) c = 9'h121;
    else if (k < b5) c = 9'h120;
    else if (k < b6) c = 9'h100;
    else             c = 9'h180;
    return {c, 1'b1, 8'hA4, (k < b6 + 1), (k >= b6 + 1)};
  endfunction

  function automatic string tag_at(int k, longint hz);
    int b1;
    b1 = cyc(512_000, hz);
    if (k < b1)                       return "R2";
    if (k == b1)                      return "R3";
    if (k < b1 + 1 + cyc(300, hz))    return "R4";
    if (k < b1 + 1 + cyc(300, hz) + 2 * cyc(2_000, hz)) return "R5";
    if (k <= b1 + 1 + cyc(300, hz) + 2 * cyc(2_000, hz) + cyc(100_000, hz)) return "R6";
    return "R7/R8";
  endfunction

  task automatic cmp(string tag, string who, logic [19:0] act, logic [19:0] exp, int k);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s k=%0d actual ctrl=%h rail=%b code=%h busy=%b done=%b expected ctrl=%h rail=%b code=%h busy=%b done=%b",
               tag, who, k, act[19:11], act[10], act[9:2], act[1], act[0],
               exp[19:11], exp[10], exp[9:2], exp[1], exp[0]);
    end
  endtask

  task automatic check_idle(string tag);
    cmp(tag, "fast", {ctrl_a, rail_a, code_a, busy_a, done_a}, 20'h0, -1);
    cmp(tag, "slow", {ctrl_b, rail_b, code_b, busy_b, done_b}, 20'h0, -1);
  endtask

  // sweep the full timeline; pulses probe R8 (busy in one instance, done in the other)
  task automatic run_seq(int kmax, bit pulses);
    @(negedge clk) start = 1'b1;
    for (int k = 0; k <= kmax; k++) begin
      @(negedge clk);
      start = pulses && (k == 10 || k == 5200 || k == 6180);
      cmp(tag_at(k, 10_000_000), "fast", {ctrl_a, rail_a, code_a, busy_a, done_a},
          expect_at(k, 10_000_000), k);
      // slow instance: R9 rounding of 300 ns to one cycle
      cmp({tag_at(k, 3_000_000), " R9"}, "slow", {ctrl_b, rail_b, code_b, busy_b, done_b},
          expect_at(k, 3_000_000), k);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk) check_idle("R1");
    rst_n = 1'b1;
    repeat (5) @(negedge clk) check_idle("R1");
    run_seq(6200, 1'b1);
    // R10: reset mid-sequence, then a full clean run
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) check_idle("R10");
    rst_n = 1'b1;
    run_seq(3000, 1'b0);
    @(negedge clk) rst_n = 1'b0;
    #1 check_idle("R10");
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk) check_idle("R10");
    run_seq(6200, 1'b0);
    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule